// File: doc/BRIEF.md
# Watchdog Timer with Shadowed Configuration

This block guards a system against runaway software. A programmable prescaler divides the clock. Each time the prescaler wraps, an 8-bit down counter steps by one. When the counter reaches zero it reloads from a software-chosen autoload value. In watchdog mode that underflow fires a fixed-length reset pulse. In timer mode it raises a sticky status flag instead. The block never raises an interrupt.

Software talks to the block through a small register port. A single write strobe carries an address and a byte, and read data is combinational from the address. Configuration written by software lands in a user copy only. The active copy that actually steers the timer is refreshed from the user copy at one moment only: when software completes a two-byte feed sequence. Stray code can therefore not silently retune or disable the watchdog. The same feed reloads the counter and clears the prescaler, so an autoload of zero still yields one full prescaler period. The active enables for the low-voltage reset, the oscillator-fail reset and the power-down block are driven out as plain outputs for circuits outside this block.

Top module: `wdog_shadowed`

## Requirements
- R1: After reset, the user and active configuration both read FBh. The autoload, counter and status registers read 00h. The reset and flag outputs are low, both reset-enable outputs are high and the power-down-block output is low. Configuration layout, MSB first: prescale select [7:5], low-voltage reset enable [4], oscillator-fail reset enable [3], power-down disable [2], run [1], mode [0] (1 = watchdog).
- R2: The counter (read at address 2) decrements each time the prescaler wraps. When it is 0 at a wrap, it underflows and reloads from the autoload register (address 1). From a feed to the resulting underflow edge there are exactly (W+1)·128·2^P clocks.
- R3: The prescaler is cleared on every feed and every reload, so an autoload of 00h gives a timeout of 128·2^P clocks.
- R4: Writes to address 0 change only the user copy. The active copy (read-only at address 4) takes the user copy only when a feed completes. The run bit alone acts straight from the user copy.
- R5: A feed is a write of A5h to address 2 immediately followed, as the next write, by 5Ah to address 2. Any other write in between cancels the sequence, and nothing about the active configuration changes.
- R6: In watchdog mode, underflow drives the reset output high on the underflow edge for exactly 4 clocks, whatever the run bit holds. In timer mode the reset output never pulses.
- R7: In timer mode, underflow sets status bit 0 (address 3, also the flag output). Writing 1 to that bit clears it, and writing 0 leaves it set.
- R8: In timer mode with the run bit 0, prescaler and counter hold their values and no underflow occurs.
- R9: The low-voltage enable, oscillator-fail enable and power-down-disable outputs follow the active copy, not the user copy.
- R10: Feeding at intervals shorter than the timeout keeps the reset output low throughout. Out of reset the first pulse comes 16384 clocks after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wdt_rst_o | output | 1 | Reset pulse on watchdog-mode underflow |
| tmr_flag_o | output | 1 | Sticky timer-mode underflow flag |
| lvd_rst_en_o | output | 1 | Active low-voltage reset enable |
| osc_rst_en_o | output | 1 | Active oscillator-fail reset enable |
| pd_block_o | output | 1 | Active power-down disable |

## Verification
The hardest case to reach from the ports is one where the user copy and the active copy disagree while the timer keeps running on the old settings. The stimulus writes a new prescale and mode into the user register and reads the active register back unchanged. It then breaks a feed with an intervening write and confirms the active register still holds the old value. Only a clean feed is allowed to move it. Underflow edges are predicted cycle-exactly from the feed edge with the timeout formula and queued, so any shift of a single clock in prescaler clearing or reload is caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic [2:0] psel;
    logic       lvd_en;
    logic       osc_en;
    logic       pd_dis;
    logic       run;
    logic       wd_mode;
  } wdog_cfg_t;

  localparam logic [7:0] CFG_RESET = 8'hFB;

  localparam int ADR_CFG    = 0;
  localparam int ADR_RELOAD = 1;
  localparam int ADR_FEED   = 2;
  localparam int ADR_STATUS = 3;
  localparam int ADR_ACTIVE = 4;

  function automatic logic hits(input logic wr, input logic [2:0] addr, input int target);
    return wr && (int'(addr) == target);
  endfunction

endpackage

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq #(
  parameter int         ADDR_W    = 3,
  parameter int         FEED_ADR  = 2,
  parameter logic [7:0] KEY_FIRST = 8'hA5,
  parameter logic [7:0] KEY_LAST  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              feed_ok
);

  logic armed_q;
  logic to_feed;

  assign to_feed = wr && (int'(addr) == FEED_ADR);

  // every write re-evaluates the armed state, so any other write cancels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (wr) armed_q <= to_feed && (wdata == KEY_FIRST);
  end

  assign feed_ok = to_feed && armed_q && (wdata == KEY_LAST);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int BASE_LOG2 = 7,
  parameter int SEL_W     = 3,
  parameter int PRE_W     = BASE_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] psel,
  output logic             tick,
  output logic [PRE_W-1:0] pre_q
);

  function automatic logic [PRE_W-1:0] wrap_point(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] span;
    span = (PRE_W+1)'(1) << (BASE_LOG2 + int'(sel));
    return PRE_W'(span - 1'b1);
  endfunction

  logic [PRE_W-1:0] limit;
  assign limit = wrap_point(psel);
  assign tick  = run && (pre_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clr)   pre_q <= '0;
    else if (tick)  pre_q <= '0;
    else if (run)   pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uflow
);

  assign uflow = tick && (cnt_q == '0) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= reload_val;
    else if (uflow)  cnt_q <= reload_val;
    else if (tick)   cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);

  localparam int PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (fire)         left_q <= PW'(RST_CYC);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

endmodule

// File: rtl/wdog_shadowed.sv
module wdog_shadowed
  import wdog_pkg::*;
#(
  parameter int         ADDR_W    = 3,
  parameter int         CNT_W     = 8,
  parameter int         BASE_LOG2 = 7,
  parameter int         SEL_W     = 3,
  parameter int         RST_CYC   = 4,
  parameter logic [7:0] KEY_FIRST = 8'hA5,
  parameter logic [7:0] KEY_LAST  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wdt_rst_o,
  output logic              tmr_flag_o,
  output logic              lvd_rst_en_o,
  output logic              osc_rst_en_o,
  output logic              pd_block_o
);

  localparam int PRE_W = BASE_LOG2 + (1 << SEL_W) - 1;

  wdog_cfg_t        usr_cfg, act_cfg;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             feed_ok, tick, uflow, run_en, mode_wd, flag_clr;

  // named internal events
  assign mode_wd  = act_cfg.wd_mode;
  assign run_en   = act_cfg.wd_mode | usr_cfg.run;
  assign flag_clr = bus_wr && (int'(bus_addr) == ADR_STATUS) && bus_wdata[0];

  wdog_feed_seq #(
    .ADDR_W(ADDR_W), .FEED_ADR(ADR_FEED), .KEY_FIRST(KEY_FIRST), .KEY_LAST(KEY_LAST)
  ) u_feed (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .feed_ok(feed_ok)
  );

  wdog_prescaler #(
    .BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W), .PRE_W(PRE_W)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(feed_ok | uflow), .run(run_en),
    .psel(SEL_W'(act_cfg.psel)), .tick(tick), .pre_q(pre_q)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(feed_ok), .tick(tick),
    .reload_val(reload_q), .cnt_q(cnt_q), .uflow(uflow)
  );

  wdog_rst_pulse #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(uflow && mode_wd), .pulse_o(wdt_rst_o)
  );

  // user copy and autoload register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_cfg  <= wdog_cfg_t'(CFG_RESET);
      reload_q <= '0;
    end else begin
      if (bus_wr && (int'(bus_addr) == ADR_CFG))    usr_cfg  <= wdog_cfg_t'(bus_wdata);
      if (bus_wr && (int'(bus_addr) == ADR_RELOAD)) reload_q <= CNT_W'(bus_wdata);
    end
  end

  // active copy moves only on a completed feed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_cfg <= wdog_cfg_t'(CFG_RESET);
    else if (feed_ok) act_cfg <= usr_cfg;
  end

  // sticky timer flag, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tmr_flag_o <= 1'b0;
    else if (uflow && !mode_wd) tmr_flag_o <= 1'b1;
    else if (flag_clr)          tmr_flag_o <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      ADR_CFG:    bus_rdata = usr_cfg;
      ADR_RELOAD: bus_rdata = 8'(reload_q);
      ADR_FEED:   bus_rdata = 8'(cnt_q);
      ADR_STATUS: bus_rdata = {7'd0, tmr_flag_o};
      ADR_ACTIVE: bus_rdata = act_cfg;
      default:    bus_rdata = '0;
    endcase
  end

  assign lvd_rst_en_o = act_cfg.lvd_en;
  assign osc_rst_en_o = act_cfg.osc_en;
  assign pd_block_o   = act_cfg.pd_dis;

endmodule

// File: rtl/wdog_shadowed_chk.sv
module wdog_shadowed_chk #(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              feed_ok,
  input logic              tick,
  input logic              uflow,
  input logic              run_en,
  input logic              mode_wd,
  input logic              flag_clr,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [PRE_W-1:0]  pre_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [7:0]        usr_cfg,
  input logic [7:0]        act_cfg,
  input logic              wdt_rst_o,
  input logic              tmr_flag_o
);

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !feed_ok && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r2_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> cnt_q == $past(reload_q));

  a_r3_prescaler_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok || uflow) |=> pre_q == '0);

  a_r4_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_ok |=> $stable(act_cfg));

  a_r4_active_takes_user: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> act_cfg == $past(usr_cfg));

  a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(uflow) && $past(mode_wd));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !mode_wd) |=> tmr_flag_o);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag_o && !flag_clr) |=> tmr_flag_o);

  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !feed_ok) |=> $stable(cnt_q) && $stable(pre_q));

endmodule

bind wdog_shadowed wdog_shadowed_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .feed_ok(feed_ok), .tick(tick), .uflow(uflow),
  .run_en(run_en), .mode_wd(mode_wd), .flag_clr(flag_clr), .cnt_q(cnt_q),
  .pre_q(pre_q), .reload_q(reload_q), .usr_cfg(usr_cfg), .act_cfg(act_cfg),
  .wdt_rst_o(wdt_rst_o), .tmr_flag_o(tmr_flag_o)
);

// File: tb/wdog_shadowed_tb.sv
module wdog_shadowed_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wdt_rst_o, tmr_flag_o, lvd_rst_en_o, osc_rst_en_o, pd_block_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit strict = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_shadowed u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o),
    .tmr_flag_o(tmr_flag_o), .lvd_rst_en_o(lvd_rst_en_o),
    .osc_rst_en_o(osc_rst_en_o), .pd_block_o(pd_block_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // timeout model restated: clocks from feed edge to underflow edge
  function automatic int timeout(input int w, input int p);
    return (w + 1) * 128 * (1 << p);
  endfunction

  task automatic push_rise(input int at, input string tag);
    exp_q.push_back(at);
    tag_q.push_back(tag);
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    bus_addr = 3'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic feed(output int e);
    bus_write(2, 8'hA5);
    bus_write(2, 8'h5A);
    e = cyc;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: pops expected reset-pulse rises, measures pulse width
  bit rst_prev = 0;
  bit measuring = 0;
  int width = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wdt_rst_o && !rst_prev) begin
        if (exp_q.size() > 0) begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, cyc, e);
          measuring = 1; width = 0;
        end else if (strict) begin
          check("R10 unexpected reset pulse", 1, 0);
        end
      end
      if (measuring) begin
        if (wdt_rst_o) width++;
        else begin
          check("R6 pulse width", width, 4);
          measuring = 0;
        end
      end
      rst_prev = wdt_rst_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e = cyc;

    // R1 reset state
    bus_read(0, d); check("R1 user cfg", d, 8'hFB);
    bus_read(4, d); check("R1 active cfg", d, 8'hFB);
    bus_read(1, d); check("R1 autoload", d, 8'h00);
    bus_read(2, d); check("R1 counter", d, 8'h00);
    bus_read(3, d); check("R1 status", d, 8'h00);
    check("R1 outputs", {wdt_rst_o, tmr_flag_o, lvd_rst_en_o, osc_rst_en_o, pd_block_o}, 5'b00110);

    // R10 first timeout from reset: P=7, W=0
    push_rise(e + timeout(0, 7), "R10 reset-default timeout");
    wait_until(e + timeout(0, 7) + 8);

    // R4 shadowing: user write does not reach active copy
    bus_write(0, 8'h03);
    bus_write(1, 8'h02);
    bus_read(4, d); check("R4 active before feed", d, 8'hFB);
    bus_read(0, d); check("R4 user copy", d, 8'h03);
    check("R9 lvd enable before feed", lvd_rst_en_o, 1'b1);
    feed(e);
    bus_read(4, d); check("R4 active after feed", d, 8'h03);
    check("R9 enables after feed", {lvd_rst_en_o, osc_rst_en_o}, 2'b00);
    push_rise(e + timeout(2, 0), "R2 timeout W=2 P=0");
    wait_until(e + 127); bus_read(2, d); check("R2 counter before wrap", d, 8'h02);
    wait_until(e + 130); bus_read(2, d); check("R2 counter after wrap", d, 8'h01);
    wait_until(e + timeout(2, 0) + 8);

    // R5 broken feed
    bus_write(0, 8'h23);
    bus_write(2, 8'hA5);
    bus_write(1, 8'h02);
    bus_write(2, 8'h5A);
    bus_read(4, d); check("R5 broken feed leaves active", d, 8'h03);
    bus_write(2, 8'hA5);
    bus_write(2, 8'hA5);
    bus_write(2, 8'h5A);
    e = cyc;
    bus_read(4, d); check("R5 re-armed feed applies", d, 8'h23);
    push_rise(e + timeout(2, 1), "R2 timeout W=2 P=1");
    wait_until(e + timeout(2, 1) + 8);

    // R3 zero autoload
    bus_write(0, 8'h03);
    bus_write(1, 8'h00);
    feed(e);
    push_rise(e + timeout(0, 0), "R3 zero autoload timeout");
    wait_until(e + timeout(0, 0) + 8);

    // R10 keep-alive with power-down disable set (R9)
    bus_write(0, 8'h07);
    bus_write(1, 8'h01);
    feed(e);
    check("R9 pd block follows active", pd_block_o, 1'b1);
    strict = 1;
    for (int i = 0; i < 5; i++) begin
      wait_until(e + 200);
      feed(e);
    end
    check("R10 no pulse while fed", wdt_rst_o, 1'b0);
    strict = 0;

    // R7 timer mode flag
    bus_write(0, 8'h02);
    bus_write(1, 8'h01);
    feed(e);
    strict = 1;
    check("R9 pd block cleared by feed", pd_block_o, 1'b0);
    wait_until(e + timeout(1, 0) - 1); check("R7 flag before underflow", tmr_flag_o, 1'b0);
    wait_until(e + timeout(1, 0));     check("R7 flag at underflow", tmr_flag_o, 1'b1);
    check("R6 no pulse in timer mode", wdt_rst_o, 1'b0);
    bus_write(3, 8'h00);
    bus_read(3, d); check("R7 write 0 keeps flag", d, 8'h01);
    bus_write(3, 8'h01);
    bus_read(3, d); check("R7 write 1 clears flag", d, 8'h00);

    // R8 stopped in timer mode
    bus_write(0, 8'h00);
    bus_read(2, d);
    wait_until(cyc + 300);
    bus_read(2, d2); check("R8 counter held", d2, d);
    check("R8 no underflow while stopped", tmr_flag_o, 1'b0);

    // R6 watchdog mode ignores run=0
    bus_write(0, 8'h01);
    bus_write(1, 8'h00);
    feed(e);
    strict = 0;
    push_rise(e + timeout(0, 0), "R6 watchdog runs with run bit 0");
    wait_until(e + timeout(0, 0) + 8);

    check("R2 all expected pulses seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule